// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor Core

This block is a small 16-bit stored-program processor. Instructions and data are held in two separate memories. The core keeps a program counter, an instruction register, a 16-entry by 16-bit register file and an ALU. A control state machine runs each instruction through three phases: fetch, decode and execute. The instruction memory is outside the core and is read combinationally through an address/data pair. The data memory is also outside the core and is read combinationally. A write to it is a single-cycle write strobe that the memory captures at the clock edge.

Every instruction is one 16-bit word with a 4-bit opcode in bits [15:12]. There are six operations:

- move a data-memory word into a register;
- move a register into data memory;
- add two registers;
- subtract two registers;
- load an 8-bit constant into a register;
- branch relative to the current instruction when a register is zero.

The reset input is asserted asynchronously. Its release is synchronised inside the block by two flops, so the controller leaves its initial state on the third rising edge after release.

Top module: `mini_cpu`

## Requirements
- R1: While reset is held, and in the cycles before the first fetch, the instruction address is 0 and both data strobes are low. The first fetch reads address 0 on the third clock edge after reset is released.
- R2: Instruction fields and timing.
  - The opcode sits in bits [15:12] and the first register index in [11:8].
  - Every defined instruction other than a taken branch takes exactly three cycles: fetch, decode and one execute cycle.
  - The program counter increments by one in the fetch cycle.
- R3: Opcode 0000 copies the data-memory word at the address in bits [7:0] into the register indexed by [11:8]. The read strobe is high for exactly one cycle per such instruction.
- R4: Opcode 0001 writes the register indexed by [11:8] to the data-memory address in [7:0]. It does so with a one-cycle write strobe.
- R5: Opcodes 0010 (add) and 0100 (subtract) write the sum or difference of registers [7:4] and [3:0] to register [11:8]. The result is taken modulo 2^16.
- R6: Opcode 0011 writes the 8-bit constant in [7:0] to register [11:8], zero-extended to 16 bits.
- R7: Opcode 0101 tests register [11:8].
  - When that register is zero, execution continues at the branch's own address plus the sign-extended 8-bit offset in [7:0]. This costs one extra cycle, four in total.
  - When that register is nonzero, execution continues at the next address after three cycles.
- R8: Any opcode above 0101 changes no register and no memory. It takes two cycles (fetch and decode), after which the next address is fetched.
- R9: The data read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| imem_addr | output | 16 | Instruction address (program counter) |
| imem_data | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 8 | Data-memory address |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_wdata | output | 16 | Data to write |
| dmem_rdata | input | 16 | Data read from dmem_addr |

## Verification
A counting program tallies the nonzero words among D[4] and D[5] and stores the tally at D[9]. It runs for all four zero/nonzero combinations of those two words. The stored value and the cycle of the store together separate taken branches from untaken ones, and they expose a branch target that is off by one.

A second program exercises the rest of the instruction set:
- a subtract that wraps below zero;
- an add;
- a constant with its top bit set, which checks zero extension;
- an undefined opcode aimed at a live register, whose two-cycle no-op shifts every later store by one cycle;
- an untaken branch with a negative offset.

In both programs, a backward branch traps execution in a two-instruction loop. The bench checks that fetch addresses then stay inside that loop, which confirms the negative-offset target arithmetic.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int IW     = 16;  // instruction width
  localparam int RIDX_W = 4;   // register index width
  localparam int FLD_W  = 8;   // address / constant / offset field width

  localparam logic [3:0] OP_LD  = 4'b0000;
  localparam logic [3:0] OP_ST  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_LDC = 4'b0011;
  localparam logic [3:0] OP_SUB = 4'b0100;
  localparam logic [3:0] OP_JZ  = 4'b0101;

  typedef enum logic [3:0] {
    S_INIT, S_FETCH, S_DECODE, S_LD, S_ST, S_ADD, S_LDC, S_SUB, S_JZ, S_JMP
  } state_t;

  typedef enum logic [1:0] {ALU_PASS = 2'b00, ALU_ADD = 2'b01, ALU_SUB = 2'b10} alu_op_t;
  typedef enum logic [1:0] {WS_ALU = 2'b00, WS_MEM = 2'b01, WS_CONST = 2'b10} wsel_t;
endpackage

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] paddr,
  output logic [W-1:0]  pdata,
  input  logic [AW-1:0] qaddr,
  output logic [W-1:0]  qdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic [W-1:0] row_q;
    logic         row_en;
    assign row_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (row_en) row_q <= wdata;
    end
    assign rows[i] = row_q;
  end

  assign pdata = rows[paddr];
  assign qdata = rows[qaddr];
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  input  logic          rp_zero,
  output logic [PW-1:0] pc,
  output logic [IW-1:0] ir,
  output logic          rf_we,
  output logic          rp_from_b,
  output alu_op_t       alu_op,
  output wsel_t         wsel,
  output logic          d_rd,
  output logic          d_wr
);
  state_t        state_q, state_d;
  logic [PW-1:0] pc_q, pc_d, jmp_tgt, off_ext;
  logic [IW-1:0] ir_q;
  logic          pc_en, ir_en, undef_op;
  logic [3:0]    opc;

  assign opc      = ir_q[IW-1 -: 4];
  assign undef_op = opc > OP_JZ;

  // next state
  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_INIT:   state_d = S_FETCH;
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (opc)
          OP_LD:   state_d = S_LD;
          OP_ST:   state_d = S_ST;
          OP_ADD:  state_d = S_ADD;
          OP_LDC:  state_d = S_LDC;
          OP_SUB:  state_d = S_SUB;
          OP_JZ:   state_d = S_JZ;
          default: state_d = S_FETCH;
        endcase
      end
      S_JZ:    state_d = rp_zero ? S_JMP : S_FETCH;
      default: state_d = S_FETCH;
    endcase
  end

  // program counter next value; the jump adder undoes the fetch increment
  assign off_ext = {{(PW-FLD_W){ir_q[FLD_W-1]}}, ir_q[FLD_W-1:0]};
  assign jmp_tgt = pc_q + off_ext - PW'(1);

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    case (state_q)
      S_INIT:  begin pc_en = 1'b1; pc_d = '0;            end
      S_FETCH: begin pc_en = 1'b1; pc_d = pc_q + PW'(1); end
      S_JMP:   begin pc_en = 1'b1; pc_d = jmp_tgt;       end
      default: ;
    endcase
  end
  assign ir_en = (state_q == S_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_INIT;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ir_en) ir_q <= instr;
  end

  // datapath controls
  assign rf_we     = (state_q == S_LD) || (state_q == S_ADD) ||
                     (state_q == S_LDC) || (state_q == S_SUB);
  assign rp_from_b = (state_q == S_ADD) || (state_q == S_SUB);
  assign alu_op    = (state_q == S_SUB) ? ALU_SUB : (state_q == S_ADD) ? ALU_ADD : ALU_PASS;
  assign wsel      = (state_q == S_LD) ? WS_MEM : (state_q == S_LDC) ? WS_CONST : WS_ALU;
  assign d_rd      = (state_q == S_LD);
  assign d_wr      = (state_q == S_ST);
  assign pc        = pc_q;
  assign ir        = ir_q;

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_rd && d_wr));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH) |=> (pc_q == $past(pc_q) + PW'(1)));
  assert_exec_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {S_LD, S_ST, S_ADD, S_LDC, S_SUB, S_JMP}) |=> (state_q == S_FETCH));
  assert_untaken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_JZ && !rp_zero) |=> (state_q == S_FETCH && $stable(pc_q)));
  assert_jmp_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_JMP) |-> ($past(state_q) == S_JZ));
  assert_undef_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DECODE && undef_op) |=> (state_q == S_FETCH && $stable(pc_q)));
endmodule

// File: rtl/mini_cpu.sv
module mini_cpu
  import core_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PW-1:0]    imem_addr,
  input  logic [IW-1:0]    imem_data,
  output logic [FLD_W-1:0] dmem_addr,
  output logic             dmem_rd,
  output logic             dmem_wr,
  output logic [DW-1:0]    dmem_wdata,
  input  logic [DW-1:0]    dmem_rdata
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [IW-1:0]     ir;
  logic              rf_we, rp_from_b, rp_zero;
  alu_op_t           alu_op;
  wsel_t             wsel;
  logic [RIDX_W-1:0] ra, rb, rc, rp_addr;
  logic [DW-1:0]     rp_data, rq_data, alu_y, wdata, const_ext;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  core_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .instr(imem_data), .rp_zero(rp_zero),
    .pc(imem_addr), .ir(ir), .rf_we(rf_we), .rp_from_b(rp_from_b),
    .alu_op(alu_op), .wsel(wsel), .d_rd(dmem_rd), .d_wr(dmem_wr)
  );

  assign ra        = ir[11:8];
  assign rb        = ir[7:4];
  assign rc        = ir[3:0];
  assign rp_addr   = rp_from_b ? rb : ra;
  assign const_ext = {{(DW-FLD_W){1'b0}}, ir[FLD_W-1:0]};

  core_regfile #(.W(DW), .AW(RIDX_W)) u_rf (
    .clk(clk), .we(rf_we), .waddr(ra), .wdata(wdata),
    .paddr(rp_addr), .pdata(rp_data), .qaddr(rc), .qdata(rq_data)
  );

  core_alu #(.W(DW)) u_alu (.a(rp_data), .b(rq_data), .op(alu_op), .y(alu_y));

  always_comb begin
    case (wsel)
      WS_MEM:   wdata = dmem_rdata;
      WS_CONST: wdata = const_ext;
      default:  wdata = alu_y;
    endcase
  end

  assign rp_zero    = ~|rp_data;
  assign dmem_addr  = ir[FLD_W-1:0];
  assign dmem_wdata = rp_data;

  assert_ld_path_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    dmem_rd |-> (rf_we && wsel == WS_MEM));
  assert_st_nowrite_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    dmem_wr |-> !rf_we);
endmodule

// File: tb/sim_mini_cpu.sv
module sim_mini_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_wdata, dmem_rdata;
  logic [7:0]  dmem_addr;
  logic        dmem_rd, dmem_wr;

  logic [15:0] imem [32];
  logic [15:0] dmem [256];
  int          cyc, n_chk, n_fail, rd_cnt;
  bit          both_seen, done;

  typedef struct { int addr; int data; int cyc; string req; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  mini_cpu u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[4:0]];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) begin
    if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_store(input int addr, input int data, input int at, input string req);
    exp_t e;
    e.addr = addr; e.data = data; e.cyc = at; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor side: every store is popped and compared
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_cnt <= 0;
    end else begin
      if (dmem_rd) rd_cnt <= rd_cnt + 1;
      if (dmem_rd && dmem_wr) both_seen <= 1'b1;
      if (dmem_wr) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected store", int'(dmem_addr), 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(dmem_addr) == e.addr, {e.req, " store address"}, int'(dmem_addr), e.addr);
          check(int'(dmem_wdata) == e.data, {e.req, " store data"}, int'(dmem_wdata), e.data);
          check(cyc == e.cyc, {e.req, " store cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 32; i++) imem[i] = 16'h3300;
  endtask

  task automatic start_run();
    @(negedge clk);
    rst_n = 1'b0;
    sb_q.delete();
    repeat (2) @(negedge clk);
    check(imem_addr == 16'h0, "R1 pc in reset", int'(imem_addr), 0);
    check(!dmem_rd && !dmem_wr, "R1 strobes in reset", int'({dmem_rd, dmem_wr}), 0);
  endtask

  task automatic release_and_check();
    rst_n = 1'b1;
    wait_cyc(2);
    check(imem_addr == 16'h0 && !dmem_wr && !dmem_rd, "R1 before first fetch", int'(imem_addr), 0);
    wait_cyc(4);
    check(imem_addr == 16'h1, "R2 pc after first fetch", int'(imem_addr), 1);
  endtask

  task automatic check_loop(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (imem_addr < 16'd9 || imem_addr > 16'd11) begin ok = 1'b0; bad = int'(imem_addr); end
    end
    check(ok, req, bad, 9);
  endtask

  task automatic run_count(input logic [15:0] v4, input logic [15:0] v5);
    int zeros, cnt;
    start_run();
    clear_imem();
    imem[0]  = 16'h3000;  // R0 = 0
    imem[1]  = 16'h3101;  // R1 = 1
    imem[2]  = 16'h0204;  // R2 = D[4]
    imem[3]  = 16'h5202;  // if R2 == 0 skip one
    imem[4]  = 16'h2001;  // R0 = R0 + R1
    imem[5]  = 16'h0205;  // R2 = D[5]
    imem[6]  = 16'h5202;
    imem[7]  = 16'h2001;
    imem[8]  = 16'h1009;  // D[9] = R0
    imem[9]  = 16'h3300;  // R3 = 0
    imem[10] = 16'h53FF;  // jump back to 9
    dmem[4] = v4; dmem[5] = v5; dmem[9] = 16'hDEAD;
    zeros = int'(v4 == 0) + int'(v5 == 0);
    cnt   = 2 - zeros;
    // taken branch costs one cycle more and skips a 3-cycle add: -2 per zero word
    expect_store(9, cnt, 29 - 2 * zeros, "R7");
    release_and_check();
    wait_cyc(40);
    check(sb_q.size() == 0, "R4 count store seen", sb_q.size(), 0);
    check(dmem[9] == 16'(cnt), "R7 tally in D[9]", int'(dmem[9]), cnt);
    check(rd_cnt == 2, "R3 read strobe cycles", rd_cnt, 2);
    check_loop("R7 backward branch loop");
  endtask

  task automatic run_mix();
    start_run();
    clear_imem();
    imem[0]  = 16'h34F0;  // R4 = 0x00F0
    imem[1]  = 16'h0520;  // R5 = D[0x20]
    imem[2]  = 16'h4645;  // R6 = R4 - R5
    imem[3]  = 16'h2755;  // R7 = R5 + R5
    imem[4]  = 16'hA755;  // undefined opcode
    imem[5]  = 16'h1621;  // D[0x21] = R6
    imem[6]  = 16'h1722;  // D[0x22] = R7
    imem[7]  = 16'h1423;  // D[0x23] = R4
    imem[8]  = 16'h55F0;  // R5 nonzero: not taken
    imem[9]  = 16'h3300;
    imem[10] = 16'h53FF;
    dmem[32] = 16'h1234;
    expect_store(33, 16'hEEBC, 19, "R5");  // undefined op is 2 cycles
    expect_store(34, 16'h2468, 22, "R8");
    expect_store(35, 16'h00F0, 25, "R6");
    release_and_check();
    wait_cyc(40);
    check(sb_q.size() == 0, "R4 mix stores seen", sb_q.size(), 0);
    check(dmem[34] == 16'h2468, "R8 register untouched by undefined op", int'(dmem[34]), 16'h2468);
    check(rd_cnt == 1, "R3 single read strobe", rd_cnt, 1);
    check_loop("R7 untaken branch then loop");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; both_seen = 1'b0; done = 1'b0;
    for (int i = 0; i < 256; i++) dmem[i] = 16'h0;
    clear_imem();
    run_count(16'h0000, 16'h0000);
    run_count(16'h0000, 16'h0005);
    run_count(16'h8000, 16'h0000);
    run_count(16'h0003, 16'hFFFF);
    run_mix();
    check(!both_seen, "R9 read and write together", int'(both_seen), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule